// File: doc/BRIEF.md
# Two-Bank Masked Interrupt Aggregator

This block gathers up to sixty-four interrupt source lines into one interrupt request for a processor. The lines come in two banks of thirty-two, a low bank and a high bank. For each line the block keeps a pending bit. A rising edge on the line sets that bit. A falling edge on the line, or software writing a one to that bit position, clears it. Each bank also has an enable mask. The interrupt request is a flop that is high whenever any pending bit is set together with its enable bit.

Software reaches the block through a 32-bit register port with a one-cycle access. It can read a fixed version word, read the pending bits of a bank after the mask is applied, read and write each bank's enable mask, and clear pending bits with a write-ones-to-clear register. Source lines are taken as synchronous to the block clock.

Top module: `intr_aggregator`

## Requirements
- R1: A read at byte offset 0x00 returns 0x02000000. Writes to 0x00 change nothing.
- R2: A read at 0x10 returns the high-bank pending bits ANDed with the high-bank enable mask. A read at 0x20 does the same for the low bank. Bit i of each word belongs to source line i of that bank.
- R3: Offset 0x14 (high bank) and offset 0x24 (low bank) hold the enable masks. A write replaces the mask with the write data, and a read returns the mask.
- R4: A write to 0x18 (high bank) or to 0x28 (low bank) clears every pending bit of that bank whose write-data bit is 1 and leaves the others as they were. A read of 0x18 or 0x28 returns zero.
- R5: Offsets 0x1C and 0x2C are reserved, and so is every other offset not listed here, including unaligned ones. Reads of these offsets return zero, and writes to them change no state.
- R6: A rising edge on a source line, seen between two consecutive clock samples, sets its pending bit. A falling edge clears it.
- R7: If a line rises in the same cycle that a clear write targets its bit, the pending bit is left set.
- R8: `cpu_irq` is a flop. After each clock edge it equals the OR, over both banks, of (pending AND enable) as that state stands after the same edge.
- R9: While reset is asserted, all pending bits, enable masks, the read data and `cpu_irq` are zero.
- R10: Read data is registered. A read presented before an edge returns the state from before that edge, and the value appears after that edge. `rsp_rdata` keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lo | input | 32 | Low-bank source lines |
| src_hi | input | 32 | High-bank source lines |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Registered interrupt request |

## Verification
Each result has a fixed due time. A source edge, an enable write or a clear write presented before clock edge k shows in the pending state and in `cpu_irq` right after edge k. Read data also appears right after edge k, but it reflects the state from before that edge. The bench drives every input at the falling edge. A behavioural model then advances one step per rising edge, and both outputs are compared with the model at the next falling edge, every cycle. Directed steps cover each corner case, including a rise that coincides with a clear. A long run of random accesses mixed with slowly toggling sources follows them.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

  localparam int NUM_BANKS = 2;
  localparam int BANK_LO   = 0;
  localparam int BANK_HI   = 1;

  localparam logic [31:0] VERSION_WORD = 32'h0200_0000;
  localparam int          OFS_VERSION  = 'h00;

  typedef enum logic [1:0] {
    REG_MASKED   = 2'd0,
    REG_ENABLE   = 2'd1,
    REG_CLEAR    = 2'd2,
    REG_RESERVED = 2'd3
  } bank_reg_e;

  // Base offset of each bank's 16-byte register window.
  function automatic int bank_base(input int b);
    return (b == BANK_LO) ? 'h20 : 'h10;
  endfunction

endpackage

// File: rtl/intr_bank.sv
module intr_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] masked_o,
  output logic [W-1:0] status_next_o,
  output logic [W-1:0] enable_next_o
);

  logic [W-1:0] level_q, level_d;
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] enable_q, enable_d;
  logic [W-1:0] rise, fall;

  always_comb begin
    rise     = src_i & ~level_q;
    fall     = ~src_i & level_q;
    level_d  = src_i;
    // A new rising edge overrides a clear aimed at the same bit.
    status_d = rise | (status_q & ~fall & ~clr_mask_i);
    enable_d = en_we_i ? en_wdata_i : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      status_q <= '0;
      enable_q <= '0;
    end else begin
      level_q  <= level_d;
      status_q <= status_d;
      if (en_we_i) enable_q <= enable_d;
    end
  end

  assign status_o      = status_q;
  assign enable_o      = enable_q;
  assign masked_o      = status_q & enable_q;
  assign status_next_o = status_d;
  assign enable_next_o = enable_d;

  assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status_q & $past(rise)) == $past(rise)));

  assert_fall_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |=> ((status_q & $past(fall)) == '0));

  assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask_i & ~rise)) |=> ((status_q & $past(clr_mask_i & ~rise)) == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask_i & rise)) |=> ((status_q & $past(clr_mask_i & rise)) == $past(clr_mask_i & rise)));

  assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> (enable_q == $past(en_wdata_i)));

endmodule

// File: rtl/intr_regif.sv
module intr_regif
  import intr_agg_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = VERSION_WORD
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [DATA_W-1:0]                req_wdata,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] masked_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] enable_i,
  output logic [NUM_BANKS-1:0]             en_we_o,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] clr_mask_o,
  output logic [DATA_W-1:0]                rdata_o
);

  localparam int WIN_LSB = 4;

  logic                 word_aligned;
  logic                 version_hit;
  logic                 wr_access;
  logic                 rd_access;
  logic [NUM_BANKS-1:0] bank_hit;
  bank_reg_e            sel;
  logic [DATA_W-1:0]    rdata_d, rdata_q;

  assign word_aligned = (req_addr[1:0] == 2'b00);
  assign version_hit  = (req_addr == ADDR_W'(OFS_VERSION));
  assign wr_access    = req_valid & req_write;
  assign rd_access    = req_valid & ~req_write;
  assign sel          = bank_reg_e'(req_addr[3:2]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(bank_base(b));
    assign bank_hit[b]   = word_aligned && (req_addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
    assign en_we_o[b]    = wr_access && bank_hit[b] && (sel == REG_ENABLE);
    assign clr_mask_o[b] = (wr_access && bank_hit[b] && (sel == REG_CLEAR)) ? req_wdata : '0;
  end

  always_comb begin
    rdata_d = '0;
    if (version_hit) rdata_d = DATA_W'(VERSION);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (sel)
          REG_MASKED: rdata_d = masked_i[b];
          REG_ENABLE: rdata_d = enable_i[b];
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_access) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_access && version_hit) |=> (rdata_o == DATA_W'(VERSION)));

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_access && !version_hit && !(|bank_hit)) |=> (rdata_o == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_access |=> $stable(rdata_o));

  assert_one_write_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_we_o));

endmodule

// File: rtl/intr_irq_reg.sv
module intr_irq_reg #(
  parameter int NB = 2,
  parameter int W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB-1:0][W-1:0] status_next_i,
  input  logic [NB-1:0][W-1:0] enable_next_i,
  output logic                 irq_o
);

  logic any_d, irq_q;

  always_comb begin
    any_d = 1'b0;
    for (int b = 0; b < NB; b++) any_d = any_d | (|(status_next_i[b] & enable_next_i[b]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_d;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import intr_agg_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = VERSION_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_lo,
  input  logic [DATA_W-1:0] src_hi,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cpu_irq
);

  logic [NUM_BANKS-1:0][DATA_W-1:0] src_bank;
  logic [NUM_BANKS-1:0][DATA_W-1:0] status, enable, masked;
  logic [NUM_BANKS-1:0][DATA_W-1:0] status_next, enable_next;
  logic [NUM_BANKS-1:0][DATA_W-1:0] clr_mask;
  logic [NUM_BANKS-1:0]             en_we;

  assign src_bank[BANK_LO] = src_lo;
  assign src_bank[BANK_HI] = src_hi;

  intr_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .masked_i   (masked),
    .enable_i   (enable),
    .en_we_o    (en_we),
    .clr_mask_o (clr_mask),
    .rdata_o    (rsp_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intr_bank #(.W(DATA_W)) u_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .src_i         (src_bank[b]),
      .en_we_i       (en_we[b]),
      .en_wdata_i    (req_wdata),
      .clr_mask_i    (clr_mask[b]),
      .status_o      (status[b]),
      .enable_o      (enable[b]),
      .masked_o      (masked[b]),
      .status_next_o (status_next[b]),
      .enable_next_o (enable_next[b])
    );
  end

  intr_irq_reg #(.NB(NUM_BANKS), .W(DATA_W)) u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .status_next_i (status_next),
    .enable_next_i (enable_next),
    .irq_o         (cpu_irq)
  );

  assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == ((|(status[BANK_LO] & enable[BANK_LO])) || (|(status[BANK_HI] & enable[BANK_HI]))));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (!cpu_irq && (status == '0) && (enable == '0) && (rsp_rdata == '0)));

endmodule

// File: tb/test_intr_aggregator.sv
module test_intr_aggregator;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_lo, src_hi;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic        cpu_irq;

  always #5ns clk = ~clk;

  intr_aggregator i_intr_aggregator (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lo    (src_lo),
    .src_hi    (src_hi),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .cpu_irq   (cpu_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state
  logic [31:0] m_st_lo = '0, m_st_hi = '0, m_en_lo = '0, m_en_hi = '0;
  logic [31:0] m_prev_lo = '0, m_prev_hi = '0, m_rdata = '0;
  logic        m_irq = 1'b0;
  logic [31:0] cur_lo = '0, cur_hi = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return 32'h0200_0000;
      8'h10:   return m_st_hi & m_en_hi;
      8'h14:   return m_en_hi;
      8'h20:   return m_st_lo & m_en_lo;
      8'h24:   return m_en_lo;
      default: return 32'h0;
    endcase
  endfunction

  // One clock: drive at falling edge, advance model at rising edge, compare at next falling edge.
  task automatic step(input logic v, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] rd_exp, rise_lo, rise_hi, fall_lo, fall_hi, clr_lo, clr_hi;
    src_lo = cur_lo; src_hi = cur_hi;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    rd_exp = model_read(a);
    @(posedge clk);
    rise_lo = cur_lo & ~m_prev_lo; fall_lo = ~cur_lo & m_prev_lo;
    rise_hi = cur_hi & ~m_prev_hi; fall_hi = ~cur_hi & m_prev_hi;
    clr_lo = (v && w && a == 8'h28) ? d : '0;
    clr_hi = (v && w && a == 8'h18) ? d : '0;
    m_st_lo = rise_lo | (m_st_lo & ~fall_lo & ~clr_lo);
    m_st_hi = rise_hi | (m_st_hi & ~fall_hi & ~clr_hi);
    if (v && w && a == 8'h24) m_en_lo = d;
    if (v && w && a == 8'h14) m_en_hi = d;
    m_prev_lo = cur_lo; m_prev_hi = cur_hi;
    if (v && !w) m_rdata = rd_exp;
    m_irq = |(m_st_lo & m_en_lo) || |(m_st_hi & m_en_hi);
    @(negedge clk);
    chk({tag, " irq R8"}, {31'h0, cpu_irq}, {31'h0, m_irq});
    chk({tag, " rdata"}, rsp_rdata, m_rdata);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 8'h00, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_lo = '0; src_hi = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 irq in reset", {31'h0, cpu_irq}, 32'h0);
    chk("R9 rdata in reset", rsp_rdata, 32'h0);
    rst_n = 1'b1;

    rd(8'h20, "R9 low masked after reset");
    rd(8'h14, "R9 high enable after reset");
    rd(8'h00, "R1 version");
    wr(8'h00, 32'hFFFF_FFFF, "R1 version write");
    rd(8'h00, "R1 version after write");

    cur_lo = 32'h0000_0008;
    idle("R6 low rise while masked");
    rd(8'h20, "R2 masked view hides pending");
    wr(8'h24, 32'h0000_0008, "R3 low enable write");
    rd(8'h24, "R3 low enable read");
    rd(8'h20, "R2 low masked read");
    idle("R10 rdata hold");

    wr(8'h28, 32'h0000_0008, "R4 low clear");
    rd(8'h20, "R4 low after clear");
    rd(8'h28, "R4 clear reg reads zero");

    cur_lo = 32'h0;
    idle("R6 low fall");
    cur_lo = 32'h0000_0008;
    wr(8'h28, 32'h0000_0008, "R7 rise with clear");
    rd(8'h20, "R7 bit still pending");
    cur_lo = 32'h0;
    idle("R6 fall clears pending");
    rd(8'h20, "R6 low after fall");

    wr(8'h14, 32'hFFFF_0000, "R3 high enable write");
    cur_hi = 32'h8000_0001;
    idle("R8 high rise");
    rd(8'h10, "R2 high masked read");
    wr(8'h18, 32'h0000_0001, "R4 high partial clear");
    rd(8'h10, "R4 high partial");
    wr(8'h18, 32'hFFFF_FFFF, "R4 high full clear");
    rd(8'h10, "R4 high empty");

    wr(8'h1C, 32'hFFFF_FFFF, "R5 reserved high write");
    rd(8'h1C, "R5 reserved high read");
    rd(8'h14, "R5 enable untouched");
    wr(8'h2C, 32'hFFFF_FFFF, "R5 reserved low write");
    rd(8'h24, "R5 low enable untouched");
    wr(8'h15, 32'h0, "R5 unaligned write");
    rd(8'h14, "R5 after unaligned write");
    rd(8'h15, "R5 unaligned read");
    rd(8'h30, "R5 unmapped read");
    rd(8'h04, "R5 unmapped low read");

    for (int i = 0; i < 600; i++) begin
      logic [7:0] addrs [12];
      logic [31:0] dat;
      int sel;
      addrs = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                8'h24, 8'h28, 8'h2C, 8'h30, 8'h04, 8'h13};
      cur_lo = cur_lo ^ ($urandom & $urandom & $urandom);
      cur_hi = cur_hi ^ ($urandom & $urandom & $urandom);
      sel = int'($urandom_range(0, 11));
      dat = $urandom;
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), addrs[sel], dat, "R2 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule